// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block decides, every cycle, which stages of a seven-stage in-order integer pipeline may move forward. The stages run fetch, decode, register access, execute, memory, exception and write-back. The instruction in register access presents a short descriptor: its destination, its two sources and its load, multiply, condition-code-setting and conditional-branch flags, plus a predicted-taken hint. The controller keeps its own copy of the descriptors that have moved into execute and beyond. From these it finds three hazards. The first is load-use. The second is use of a multiply result, which counts only when the multiplier is pipelined. The third is a conditional branch or trap that follows too closely behind an instruction that sets the condition codes.

When a hazard is found, the front three stages stay where they are. The back four stages advance, and an empty slot enters execute. A hold request from the caches or store buffer, or a separate one from the floating-point unit, freezes every stage. While a hold is asserted, no stage moves and no bubble is spent. A hazard that is waiting when the hold starts therefore still costs its bubble once the hold ends. With no hazard and no hold, one instruction issues every cycle.

Top module: `pipe_interlock_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the valid bits of the execute, memory, exception and write-back slots (`pipe_valid_o` = 0000).
- R2: With no hazard and no hold, `adv_o` is all ones (bit 0 = fetch through bit 6 = write-back) and `bubble_o` is 0. Each cycle the register-access valid bit moves into `pipe_valid_o[0]`, and every other slot moves one place up (bit 0 execute to bit 3 write-back).
- R3: An instruction that reads (rs1 or rs2) the nonzero destination of a valid load sitting in execute stalls for exactly one cycle. During that cycle `adv_o[2:0]`=000, `adv_o[6:3]`=1111 and `bubble_o`=1, and on the next edge execute becomes empty while the later slots still shift.
- R4: A source or destination of register 0 never creates a dependency. An instruction whose valid bit is clear, whether in register access or in execute, never causes a stall.
- R5: When `cfg_pipe_mul`=1, an instruction that reads the nonzero destination of a valid multiply in execute gets one bubble. When `cfg_pipe_mul`=0, a multiply causes no stall.
- R6: A conditional branch or trap in register access stalls while a valid condition-code setter occupies execute or memory. A setter immediately ahead therefore costs two bubbles, a setter with one instruction between costs one, and a setter two or more instructions ahead costs none.
- R7: When `cfg_pred_en`=1 and `ra_pred_taken`=1, the condition-code stall of R6 does not apply. A branch predicted not taken still stalls as in R6.
- R8: While `hold_req` or `fpu_hold` is high, `adv_o` is 0000000 and `bubble_o` is 0, and `pipe_valid_o` keeps its value across the edge.
- R9: A hold does not absorb a hazard. After the hold drops, a hazard that was waiting when it started still produces its full bubble count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pred_en | input | 1 | Static branch prediction enable (quasi-static) |
| cfg_pipe_mul | input | 1 | Pipelined multiplier mode (quasi-static) |
| hold_req | input | 1 | Hold from cache miss or store-buffer blocking |
| fpu_hold | input | 1 | Hold from the floating-point unit |
| ra_valid | input | 1 | Register-access instruction is valid |
| ra_rd | input | 5 | Destination register of the register-access instruction |
| ra_rs1 | input | 5 | First source register |
| ra_rs2 | input | 5 | Second source register |
| ra_is_load | input | 1 | Instruction is a load |
| ra_is_mul | input | 1 | Instruction is a multiply |
| ra_sets_cc | input | 1 | Instruction writes the condition codes |
| ra_is_bcc | input | 1 | Instruction is a conditional branch or trap |
| ra_pred_taken | input | 1 | Static prediction hint: taken |
| adv_o | output | 7 | Per-stage advance enable, bit 0 fetch to bit 6 write-back |
| bubble_o | output | 1 | A bubble is inserted into execute this cycle |
| pipe_valid_o | output | 4 | Valid bits of execute, memory, exception, write-back (bit 0 = execute) |

## Verification
A hold and an interlock can fall in the same cycle. This happens when a load that misses sits in execute with a dependent instruction waiting behind it, or when a branch is stopped behind a condition-code setter while the floating-point unit holds. The bench provokes this in a directed case with a multi-cycle hold over a waiting load-use hazard. Random runs also raise holds often while hazard-rich traffic flows through a small register set. A reference model in the bench judges every cycle. It requires a complete freeze while the hold lasts and then the full bubble count after it drops.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;
  parameter int unsigned RA_W     = 5;
  parameter int unsigned N_STAGE  = 7;
  parameter int unsigned N_BACK   = 4;
  localparam int unsigned ST_RA   = 2;
  localparam int unsigned ST_EX   = 3;

  typedef struct packed {
    logic            vld;
    logic [RA_W-1:0] rd;
    logic            ld;
    logic            mul;
    logic            setcc;
  } slot_t;
endpackage

// File: rtl/ilk_slot_pipe.sv
module ilk_slot_pipe
  import pipe_ilk_pkg::*;
#(
  parameter int unsigned DEPTH = N_BACK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             move,
  input  logic             bubble,
  input  slot_t            entry,
  output slot_t            ex_slot,
  output slot_t            me_slot,
  output logic [DEPTH-1:0] valid_vec
);
  slot_t q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      q[0] <= '0;
    end else if (move) begin
      q[0] <= bubble ? '0 : entry;
    end
  end

  genvar i;
  generate
    for (i = 1; i < DEPTH; i++) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) begin
          q[i] <= '0;
        end else if (move) begin
          q[i] <= q[i-1];
        end
      end
    end
    for (i = 0; i < DEPTH; i++) begin : g_vld
      assign valid_vec[i] = q[i].vld;
    end
  endgenerate

  assign ex_slot = q[0];
  assign me_slot = q[1];
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import pipe_ilk_pkg::*;
(
  input  logic            cfg_pred_en,
  input  logic            cfg_pipe_mul,
  input  logic            ra_valid,
  input  logic [RA_W-1:0] ra_rs1,
  input  logic [RA_W-1:0] ra_rs2,
  input  logic            ra_is_bcc,
  input  logic            ra_pred_taken,
  input  slot_t           ex_slot,
  input  slot_t           me_slot,
  output logic            load_use,
  output logic            mul_use,
  output logic            cc_wait
);
  logic reads_ex;
  logic cc_pending;
  logic skip_cc;

  function automatic logic reads_reg(input logic [RA_W-1:0] src,
                                     input logic [RA_W-1:0] dst);
    return (src != '0) && (src == dst);
  endfunction

  always_comb begin
    reads_ex   = reads_reg(ra_rs1, ex_slot.rd) || reads_reg(ra_rs2, ex_slot.rd);
    cc_pending = (ex_slot.vld && ex_slot.setcc) || (me_slot.vld && me_slot.setcc);
    skip_cc    = cfg_pred_en && ra_pred_taken;
    load_use   = ra_valid && ex_slot.vld && ex_slot.ld && reads_ex;
    mul_use    = cfg_pipe_mul && ra_valid && ex_slot.vld && ex_slot.mul && reads_ex;
    cc_wait    = ra_valid && ra_is_bcc && !skip_cc && cc_pending;
  end
endmodule

// File: rtl/ilk_advance.sv
module ilk_advance
  import pipe_ilk_pkg::*;
(
  input  logic               hold,
  input  logic               stall,
  output logic [N_STAGE-1:0] adv,
  output logic               bubble
);
  genvar s;
  generate
    for (s = 0; s < N_STAGE; s++) begin : g_adv
      if (s <= ST_RA) begin : g_front
        assign adv[s] = !hold && !stall;
      end else begin : g_back
        assign adv[s] = !hold;
      end
    end
  endgenerate

  assign bubble = stall && !hold;
endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
  import pipe_ilk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_pred_en,
  input  logic               cfg_pipe_mul,
  input  logic               hold_req,
  input  logic               fpu_hold,
  input  logic               ra_valid,
  input  logic [RA_W-1:0]    ra_rd,
  input  logic [RA_W-1:0]    ra_rs1,
  input  logic [RA_W-1:0]    ra_rs2,
  input  logic               ra_is_load,
  input  logic               ra_is_mul,
  input  logic               ra_sets_cc,
  input  logic               ra_is_bcc,
  input  logic               ra_pred_taken,
  output logic [N_STAGE-1:0] adv_o,
  output logic               bubble_o,
  output logic [N_BACK-1:0]  pipe_valid_o
);
  logic  hold;
  logic  stall;
  logic  load_use, mul_use, cc_wait;
  slot_t entry, ex_slot, me_slot;

  assign hold  = hold_req || fpu_hold;
  assign stall = load_use || mul_use || cc_wait;

  always_comb begin
    entry       = '0;
    entry.vld   = ra_valid;
    entry.rd    = ra_rd;
    entry.ld    = ra_is_load;
    entry.mul   = ra_is_mul;
    entry.setcc = ra_sets_cc;
  end

  ilk_hazard u_hazard (
    .cfg_pred_en   (cfg_pred_en),
    .cfg_pipe_mul  (cfg_pipe_mul),
    .ra_valid      (ra_valid),
    .ra_rs1        (ra_rs1),
    .ra_rs2        (ra_rs2),
    .ra_is_bcc     (ra_is_bcc),
    .ra_pred_taken (ra_pred_taken),
    .ex_slot       (ex_slot),
    .me_slot       (me_slot),
    .load_use      (load_use),
    .mul_use       (mul_use),
    .cc_wait       (cc_wait)
  );

  ilk_advance u_adv (
    .hold   (hold),
    .stall  (stall),
    .adv    (adv_o),
    .bubble (bubble_o)
  );

  ilk_slot_pipe #(.DEPTH(N_BACK)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .move      (adv_o[ST_EX]),
    .bubble    (bubble_o),
    .entry     (entry),
    .ex_slot   (ex_slot),
    .me_slot   (me_slot),
    .valid_vec (pipe_valid_o)
  );
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk
  import pipe_ilk_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cfg_pipe_mul,
  input logic               hold_req,
  input logic               fpu_hold,
  input logic               ra_valid,
  input logic [RA_W-1:0]    ra_rd,
  input logic [RA_W-1:0]    ra_rs1,
  input logic [RA_W-1:0]    ra_rs2,
  input logic               ra_is_load,
  input logic               ra_is_mul,
  input logic [N_STAGE-1:0] adv_o,
  input logic               bubble_o,
  input logic [N_BACK-1:0]  pipe_valid_o
);
  logic            hold;
  logic            c_ld, c_mul;
  logic [RA_W-1:0] c_rd;
  logic            c_reads;

  assign hold    = hold_req || fpu_hold;
  assign c_reads = (c_rd != '0) && ((ra_rs1 == c_rd) || (ra_rs2 == c_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      c_ld  <= 1'b0;
      c_mul <= 1'b0;
      c_rd  <= '0;
    end else if (!hold) begin
      c_ld  <= adv_o[ST_RA] && ra_valid && ra_is_load;
      c_mul <= adv_o[ST_RA] && ra_valid && ra_is_mul;
      c_rd  <= ra_rd;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pipe_valid_o == '0));

  p_issue_r2: assert property (@(posedge clk) disable iff (rst)
    adv_o[ST_RA] |=> (pipe_valid_o[0] == $past(ra_valid)));

  p_load_use_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && ra_valid && c_ld && c_reads) |-> (bubble_o && adv_o[ST_RA:0] == '0));

  p_bubble_empty_r3: assert property (@(posedge clk) disable iff (rst)
    bubble_o |=> !pipe_valid_o[0]);

  p_mul_use_r5: assert property (@(posedge clk) disable iff (rst)
    (!hold && cfg_pipe_mul && ra_valid && c_mul && c_reads) |-> bubble_o);

  p_hold_stop_r8: assert property (@(posedge clk) disable iff (rst)
    hold |-> (adv_o == '0 && !bubble_o));

  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(pipe_valid_o));
endmodule

bind pipe_interlock_ctrl pipe_interlock_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_pipe_mul (cfg_pipe_mul),
  .hold_req     (hold_req),
  .fpu_hold     (fpu_hold),
  .ra_valid     (ra_valid),
  .ra_rd        (ra_rd),
  .ra_rs1       (ra_rs1),
  .ra_rs2       (ra_rs2),
  .ra_is_load   (ra_is_load),
  .ra_is_mul    (ra_is_mul),
  .adv_o        (adv_o),
  .bubble_o     (bubble_o),
  .pipe_valid_o (pipe_valid_o)
);

// File: tb/pipe_interlock_ctrl_bench.sv
module pipe_interlock_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_pred_en = 1'b0, cfg_pipe_mul = 1'b0;
  logic       hold_req = 1'b0, fpu_hold = 1'b0;
  logic       ra_valid = 1'b0;
  logic [4:0] ra_rd = '0, ra_rs1 = '0, ra_rs2 = '0;
  logic       ra_is_load = 1'b0, ra_is_mul = 1'b0, ra_sets_cc = 1'b0;
  logic       ra_is_bcc = 1'b0, ra_pred_taken = 1'b0;
  logic [6:0] adv_o;
  logic       bubble_o;
  logic [3:0] pipe_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state: slots execute..write-back
  bit       mv [4];
  bit [4:0] mrd [2];
  bit       mld [2], mmul [2], mcc [2];
  bit       accepted;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_interlock_ctrl u_pipe_interlock_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit rdep(input bit [4:0] s, input bit [4:0] d);
    return (s != 0) && (s == d);
  endfunction

  task automatic set_ra(input bit v, input bit [4:0] rd, input bit [4:0] s1,
                        input bit [4:0] s2, input bit ld, input bit mu,
                        input bit cc, input bit bcc, input bit pt);
    ra_valid = v; ra_rd = rd; ra_rs1 = s1; ra_rs2 = s2; ra_is_load = ld;
    ra_is_mul = mu; ra_sets_cc = cc; ra_is_bcc = bcc; ra_pred_taken = pt;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic cyc(input string tag_in);
    bit hold, dep, ldh, mulh, cch, stall;
    bit [6:0] e_adv;
    bit [3:0] e_v;
    string tag;
    #1;
    hold  = hold_req || fpu_hold;
    dep   = rdep(ra_rs1, mrd[0]) || rdep(ra_rs2, mrd[0]);
    ldh   = ra_valid && mv[0] && mld[0] && dep;
    mulh  = cfg_pipe_mul && ra_valid && mv[0] && mmul[0] && dep;
    cch   = ra_valid && ra_is_bcc && !(cfg_pred_en && ra_pred_taken) &&
            ((mv[0] && mcc[0]) || (mv[1] && mcc[1]));
    stall = ldh || mulh || cch;
    e_adv = hold ? 7'h00 : (stall ? 7'h78 : 7'h7f);
    e_v   = {mv[3], mv[2], mv[1], mv[0]};
    if (tag_in != "") tag = tag_in;
    else if (hold) tag = "R8";
    else if (ldh) tag = "R3";
    else if (mulh) tag = "R5";
    else if (cch) tag = cfg_pred_en ? "R7" : "R6";
    else tag = "R2";
    chk(adv_o == e_adv, tag, "adv_o", adv_o, e_adv);
    chk(bubble_o == (stall && !hold), tag, "bubble_o", bubble_o, stall && !hold);
    chk(pipe_valid_o == e_v, tag, "pipe_valid_o", pipe_valid_o, e_v);
    accepted = !hold && !stall;
    if (!hold) begin
      mv[3] = mv[2]; mv[2] = mv[1]; mv[1] = mv[0];
      mrd[1] = mrd[0]; mld[1] = mld[0]; mmul[1] = mmul[0]; mcc[1] = mcc[0];
      if (stall) begin
        mv[0] = 0; mrd[0] = 0; mld[0] = 0; mmul[0] = 0; mcc[0] = 0;
      end else begin
        mv[0] = ra_valid; mrd[0] = ra_rd; mld[0] = ra_is_load;
        mmul[0] = ra_is_mul; mcc[0] = ra_sets_cc;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // present the current descriptor until it enters execute; return cycles used
  task automatic issue(input string tag, output int n);
    n = 0;
    do begin
      cyc(tag);
      n++;
    end while (!accepted && n < 50);
  endtask

  task automatic nop_n(input int k);
    for (int i = 0; i < k; i++) begin
      int n;
      set_ra(1, 0, 0, 0, 0, 0, 0, 0, 0);
      issue("", n);
    end
  endtask

  initial begin
    int n;
    for (int i = 0; i < 4; i++) mv[i] = 0;
    for (int i = 0; i < 2; i++) begin mrd[i] = 0; mld[i] = 0; mmul[i] = 0; mcc[i] = 0; end
    void'($urandom(32'h5eed_1234));
    // R1: reset clears slots
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pipe_valid_o == 4'h0, "R1", "pipe_valid_o after reset", pipe_valid_o, 0);
    rst = 0;
    // R2: independent stream, one per cycle
    for (int i = 0; i < 6; i++) begin
      set_ra(1, 5'(i+1), 5'(i+8), 0, 0, 0, 0, 0, 0);
      issue("R2", n);
      chk(n == 1, "R2", "cycles per issue", n, 1);
    end
    // R3: load-use costs one bubble
    set_ra(1, 3, 9, 0, 1, 0, 0, 0, 0); issue("R3", n);
    set_ra(1, 4, 0, 3, 0, 0, 0, 0, 0); issue("R3", n);
    chk(n == 2, "R3", "load-use cycles", n, 2);
    // R4: register zero and invalid instructions never stall
    set_ra(1, 0, 9, 0, 1, 0, 0, 0, 0); issue("R4", n);
    set_ra(1, 4, 0, 0, 0, 0, 0, 0, 0); issue("R4", n);
    chk(n == 1, "R4", "r0 consumer cycles", n, 1);
    set_ra(1, 6, 9, 0, 1, 0, 0, 0, 0); issue("R4", n);
    set_ra(0, 4, 6, 6, 0, 0, 0, 0, 0); issue("R4", n);
    chk(n == 1, "R4", "invalid consumer cycles", n, 1);
    // R5: multiply-use
    cfg_pipe_mul = 1;
    set_ra(1, 7, 1, 2, 0, 1, 0, 0, 0); issue("R5", n);
    set_ra(1, 8, 7, 0, 0, 0, 0, 0, 0); issue("R5", n);
    chk(n == 2, "R5", "mul-use cycles pipelined", n, 2);
    cfg_pipe_mul = 0;
    set_ra(1, 7, 1, 2, 0, 1, 0, 0, 0); issue("R5", n);
    set_ra(1, 8, 7, 0, 0, 0, 0, 0, 0); issue("R5", n);
    chk(n == 1, "R5", "mul-use cycles non-pipelined", n, 1);
    // R6: condition-code distance
    set_ra(1, 1, 0, 0, 0, 0, 1, 0, 0); issue("R6", n);
    set_ra(1, 0, 0, 0, 0, 0, 0, 1, 0); issue("R6", n);
    chk(n == 3, "R6", "branch right after setter", n, 3);
    set_ra(1, 1, 0, 0, 0, 0, 1, 0, 0); issue("R6", n);
    nop_n(1);
    set_ra(1, 0, 0, 0, 0, 0, 0, 1, 0); issue("R6", n);
    chk(n == 2, "R6", "branch one apart", n, 2);
    set_ra(1, 1, 0, 0, 0, 0, 1, 0, 0); issue("R6", n);
    nop_n(2);
    set_ra(1, 0, 0, 0, 0, 0, 0, 1, 0); issue("R6", n);
    chk(n == 1, "R6", "branch two apart", n, 1);
    // R7: static prediction
    cfg_pred_en = 1;
    set_ra(1, 1, 0, 0, 0, 0, 1, 0, 0); issue("R7", n);
    set_ra(1, 0, 0, 0, 0, 0, 0, 1, 1); issue("R7", n);
    chk(n == 1, "R7", "predicted taken", n, 1);
    set_ra(1, 1, 0, 0, 0, 0, 1, 0, 0); issue("R7", n);
    set_ra(1, 0, 0, 0, 0, 0, 0, 1, 0); issue("R7", n);
    chk(n == 3, "R7", "predicted not taken", n, 3);
    cfg_pred_en = 0;
    // R8/R9: hold over a waiting load-use hazard
    set_ra(1, 5, 0, 0, 1, 0, 0, 0, 0); issue("R9", n);
    set_ra(1, 6, 5, 0, 0, 0, 0, 0, 0);
    fpu_hold = 1;
    for (int i = 0; i < 3; i++) cyc("R8");
    fpu_hold = 0; hold_req = 1;
    cyc("R8");
    hold_req = 0;
    issue("R9", n);
    chk(n == 2, "R9", "bubble after hold", n, 2);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if (accepted || i == 0)
        set_ra(($urandom % 8) != 0, 5'($urandom % 4), 5'($urandom % 4),
               5'($urandom % 4), ($urandom % 5) == 0, ($urandom % 5) == 0,
               ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom % 2);
      hold_req = ($urandom % 8) == 0;
      fpu_hold = ($urandom % 20) == 0;
      if (i % 500 == 0) begin
        cfg_pred_en = $urandom % 2;
        cfg_pipe_mul = $urandom % 2;
      end
      cyc("");
    end
    hold_req = 0; fpu_hold = 0;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule